// File: doc/BRIEF.md
# Secondary Uncorrectable Error Reporter

This block collects uncorrectable errors detected on the conventional PCI / PCI-X side of a bridge that faces PCIe upstream. Each error source delivers a one-cycle pulse together with the four-word header of the transaction involved. The block records every event in a sticky status vector. It captures the header of the first reportable error together with a pointer to that error. It decides from per-error mask and severity bits, and from three enable inputs, whether a Fatal or a Non-Fatal error message must be requested from the upstream port.

Message requests wait in a small pending store that is drained through a valid/ready handshake, so a busy upstream port loses no event. Fatal requests are presented before non-fatal ones. Three sticky outputs feed other configuration registers: system error signaled, fatal error detected and non-fatal error detected. Software reaches the status, mask, severity, pointer, detect and header registers through a plain read/write port. Status and detect bits are cleared by writing ones.

Error index assignment, where a lower index wins the log: 0 = address parity error, 1 = corrupted or unexpected split completion message, 2 = data parity error in the data phase of a split completion message.

Top module: `sec_uerr_reporter`

## Requirements
- R1: A pulse on `err_pulse[i]` sets status bit i (address 0x0, bit i) on the next edge whatever the mask holds. Writing 1 to a status bit clears it. A pulse in the same cycle as the clear wins. Status resets to 0.
- R2: The header is captured into words 0..3 (addresses 0x8..0xB, word k = `err_hdr[32k+31:32k]`) and the pointer (address 0x3: bit 31 valid, bits 1:0 index) is loaded only when an unmasked error fires while the pointer is not valid. Both then hold until the pointer is invalidated.
- R3: When several unmasked errors fire in one cycle, the pointer takes the lowest such index and the header is captured once. Every firing error still sets its status bit.
- R4: Writing 1 to the status bit named by a valid pointer makes the pointer invalid. Clearing any other status bit leaves it valid. The index field keeps its last value.
- R5: Severity bit i (address 0x2) set makes error i request a Fatal message, clear a Non-Fatal one (`msg_fatal` 1 = Fatal). A pending fatal request is presented before any pending non-fatal one.
- R6: A message of a given kind is requested in a cycle only if some unmasked error of that severity fires and `serr_en` or the matching reporting enable (`fatal_rep_en` / `nonfatal_rep_en`) is 1. Masked errors (address 0x1, bit 1 = masked) request nothing.
- R7: `sig_sys_err` (detect register bit 2, address 0x4) is set only in a cycle where a message is requested while `serr_en` is 1. It is cleared by writing 1.
- R8: `fatal_det` (detect bit 0) is set by any unmasked fatal-severity error and `nonfatal_det` (detect bit 1) by any unmasked non-fatal-severity error, independently of the enables. Both are cleared by writing 1.
- R9: Requests are counted per kind, up to 4 each. `msg_valid` stays 1 while any request is pending, and one request is removed on each cycle with `msg_valid` and `msg_ready` both 1.
- R10: Mask and severity registers read back what was written and reset to 0. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | 3 | One-cycle error events, one per source |
| err_hdr | input | 128 | Header of the transaction tied to the events |
| serr_en | input | 1 | System error enable from PCI command register |
| fatal_rep_en | input | 1 | Fatal reporting enable from device control |
| nonfatal_rep_en | input | 1 | Non-fatal reporting enable from device control |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| msg_valid | output | 1 | Error message request pending |
| msg_fatal | output | 1 | Kind of the presented request, 1 = Fatal |
| msg_ready | input | 1 | Upstream port accepts the request |
| sig_sys_err | output | 1 | Sticky system-error-signaled flag |
| fatal_det | output | 1 | Sticky fatal error detected flag |
| nonfatal_det | output | 1 | Sticky non-fatal error detected flag |

## Verification
The assertions take for granted that the upstream port drains requests often enough that neither per-kind counter is pushed while full without a pop in the same cycle. The overflow property flags any stimulus that breaks this. The stimulus holds `msg_ready` low only in a short directed backlog of three requests. In the pseudo-random phase it keeps `msg_ready` high and fires errors at most every other cycle, so each counter stays below two. The header bus is assumed valid in any cycle where a pulse is present, and the bench drives a fresh header with every pulse.

// File: rtl/sec_uerr_pkg.sv
package sec_uerr_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_STATUS = 4'h0;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'h1;
  localparam logic [ADDR_W-1:0] A_SEV    = 4'h2;
  localparam logic [ADDR_W-1:0] A_PTR    = 4'h3;
  localparam logic [ADDR_W-1:0] A_DET    = 4'h4;
  localparam logic [ADDR_W-1:0] A_HDR0   = 4'h8;

  localparam int DET_FATAL = 0;
  localparam int DET_NONF  = 1;
  localparam int DET_SSE   = 2;
  localparam int PTR_VBIT  = 31;

  // Index of the lowest set bit, 0 when none is set.
  function automatic logic [4:0] lowest_set(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

  // Saturating up/down counter step.
  function automatic logic [7:0] step_count(input logic [7:0] c, input logic inc,
                                            input logic dec, input logic [7:0] cap);
    logic [7:0] r;
    r = c;
    if (inc && !dec && c != cap) r = c + 8'd1;
    else if (dec && !inc && c != 8'd0) r = c - 8'd1;
    return r;
  endfunction

endpackage

// File: rtl/sec_uerr_eval.sv
module sec_uerr_eval #(
  parameter int NUM_ERR = 3
) (
  input  logic [NUM_ERR-1:0] err_pulse,
  input  logic [NUM_ERR-1:0] mask_q,
  input  logic [NUM_ERR-1:0] sev_q,
  input  logic               serr_en,
  input  logic               fatal_rep_en,
  input  logic               nonfatal_rep_en,
  output logic [NUM_ERR-1:0] unm,
  output logic               fat_hit,
  output logic               nf_hit,
  output logic               fat_push,
  output logic               nf_push,
  output logic               sse_set
);
  always_comb begin
    unm      = err_pulse & ~mask_q;
    fat_hit  = |(unm & sev_q);
    nf_hit   = |(unm & ~sev_q);
    fat_push = fat_hit && (serr_en || fatal_rep_en);
    nf_push  = nf_hit && (serr_en || nonfatal_rep_en);
    sse_set  = serr_en && (fat_push || nf_push);
  end
endmodule

// File: rtl/sec_uerr_log.sv
module sec_uerr_log
  import sec_uerr_pkg::*;
#(
  parameter int NUM_ERR = 3,
  parameter int HDR_W   = 128,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] unm,
  input  logic [HDR_W-1:0]   hdr_in,
  input  logic [NUM_ERR-1:0] clr_bits,
  output logic               ptr_valid,
  output logic [IDX_W-1:0]   ptr_idx,
  output logic [HDR_W-1:0]   hdr_q
);
  logic               load;
  logic               clr_hit;
  logic [NUM_ERR-1:0] ptr_onehot;
  logic [4:0]         first_idx;

  always_comb begin
    first_idx  = lowest_set(32'(unm));
    ptr_onehot = NUM_ERR'(1) << ptr_idx;
    load       = !ptr_valid && (unm != '0);
    clr_hit    = ptr_valid && ((clr_bits & ptr_onehot) != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_valid <= 1'b0;
      ptr_idx   <= '0;
      hdr_q     <= '0;
    end else if (load) begin
      ptr_valid <= 1'b1;
      ptr_idx   <= IDX_W'(first_idx);
      hdr_q     <= hdr_in;
    end else if (clr_hit) begin
      ptr_valid <= 1'b0;
    end
  end

  // R2: a valid pointer and its header hold while not cleared
  p_log_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_valid && !clr_hit) |=> (ptr_valid && $stable(ptr_idx) && $stable(hdr_q)));

  // R2: nothing unmasked while free keeps the pointer free
  p_masked_noload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_valid && unm == '0) |=> !ptr_valid);

  // R3: the captured index names an error that fired unmasked
  p_idx_fired_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((($past(unm) >> ptr_idx) & NUM_ERR'(1)) != '0));

  // R4: clearing the pointed status bit invalidates the pointer
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !ptr_valid);
endmodule

// File: rtl/sec_uerr_msgq.sv
module sec_uerr_msgq
  import sec_uerr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fat_push,
  input  logic nf_push,
  input  logic msg_ready,
  output logic msg_valid,
  output logic msg_fatal
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] CAP = 8'(DEPTH);

  logic [CW-1:0] fat_cnt, nf_cnt;
  logic          pop, fat_pop, nf_pop;
  logic          fat_full, nf_full;

  always_comb begin
    msg_valid = (fat_cnt != '0) || (nf_cnt != '0);
    msg_fatal = (fat_cnt != '0);
    pop       = msg_valid && msg_ready;
    fat_pop   = pop && msg_fatal;
    nf_pop    = pop && !msg_fatal;
    fat_full  = (fat_cnt == CW'(DEPTH));
    nf_full   = (nf_cnt == CW'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fat_cnt <= '0;
      nf_cnt  <= '0;
    end else begin
      fat_cnt <= CW'(step_count(8'(fat_cnt), fat_push, fat_pop, CAP));
      nf_cnt  <= CW'(step_count(8'(nf_cnt), nf_push, nf_pop, CAP));
    end
  end

  // R9: no request is pushed into a full counter without a pop
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !((fat_push && !fat_pop && fat_full) || (nf_push && !nf_pop && nf_full)));

  // R9: a pending request stays presented until accepted
  p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);

  // R5: accepting a fatal request removes exactly one fatal entry
  p_fatal_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_fatal && !fat_push) |=> (fat_cnt == $past(fat_cnt) - CW'(1)));
endmodule

// File: rtl/sec_uerr_reporter.sv
module sec_uerr_reporter
  import sec_uerr_pkg::*;
#(
  parameter int NUM_ERR     = 3,
  parameter int HDR_WORDS   = 4,
  parameter int MSGQ_DEPTH  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_ERR-1:0]        err_pulse,
  input  logic [HDR_WORDS*32-1:0]   err_hdr,
  input  logic                      serr_en,
  input  logic                      fatal_rep_en,
  input  logic                      nonfatal_rep_en,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic                      msg_valid,
  output logic                      msg_fatal,
  input  logic                      msg_ready,
  output logic                      sig_sys_err,
  output logic                      fatal_det,
  output logic                      nonfatal_det
);
  localparam int HDR_W = HDR_WORDS * 32;
  localparam int IDX_W = (NUM_ERR > 1) ? $clog2(NUM_ERR) : 1;

  logic [NUM_ERR-1:0] status_q, mask_q, sev_q;
  logic [NUM_ERR-1:0] status_clr, unm;
  logic [2:0]         det_clr;
  logic               fat_hit, nf_hit, fat_push, nf_push, sse_set;
  logic               ptr_valid;
  logic [IDX_W-1:0]   ptr_idx;
  logic [HDR_W-1:0]   hdr_q;
  logic               wr_status, wr_mask, wr_sev, wr_det;

  always_comb begin
    wr_status  = reg_wr && (reg_addr == A_STATUS);
    wr_mask    = reg_wr && (reg_addr == A_MASK);
    wr_sev     = reg_wr && (reg_addr == A_SEV);
    wr_det     = reg_wr && (reg_addr == A_DET);
    status_clr = wr_status ? reg_wdata[NUM_ERR-1:0] : '0;
    det_clr    = wr_det ? reg_wdata[2:0] : 3'b000;
  end

  sec_uerr_eval #(.NUM_ERR(NUM_ERR)) u_eval (
    .err_pulse(err_pulse), .mask_q(mask_q), .sev_q(sev_q),
    .serr_en(serr_en), .fatal_rep_en(fatal_rep_en), .nonfatal_rep_en(nonfatal_rep_en),
    .unm(unm), .fat_hit(fat_hit), .nf_hit(nf_hit),
    .fat_push(fat_push), .nf_push(nf_push), .sse_set(sse_set)
  );

  sec_uerr_log #(.NUM_ERR(NUM_ERR), .HDR_W(HDR_W), .IDX_W(IDX_W)) u_log (
    .clk(clk), .rst_n(rst_n), .unm(unm), .hdr_in(err_hdr), .clr_bits(status_clr),
    .ptr_valid(ptr_valid), .ptr_idx(ptr_idx), .hdr_q(hdr_q)
  );

  sec_uerr_msgq #(.DEPTH(MSGQ_DEPTH)) u_msgq (
    .clk(clk), .rst_n(rst_n), .fat_push(fat_push), .nf_push(nf_push),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_fatal(msg_fatal)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q     <= '0;
      mask_q       <= '0;
      sev_q        <= '0;
      fatal_det    <= 1'b0;
      nonfatal_det <= 1'b0;
      sig_sys_err  <= 1'b0;
    end else begin
      status_q     <= (status_q & ~status_clr) | err_pulse;
      if (wr_mask) mask_q <= reg_wdata[NUM_ERR-1:0];
      if (wr_sev)  sev_q  <= reg_wdata[NUM_ERR-1:0];
      fatal_det    <= (fatal_det & ~det_clr[DET_FATAL]) | fat_hit;
      nonfatal_det <= (nonfatal_det & ~det_clr[DET_NONF]) | nf_hit;
      sig_sys_err  <= (sig_sys_err & ~det_clr[DET_SSE]) | sse_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STATUS) reg_rdata[NUM_ERR-1:0] = status_q;
    else if (reg_addr == A_MASK) reg_rdata[NUM_ERR-1:0] = mask_q;
    else if (reg_addr == A_SEV) reg_rdata[NUM_ERR-1:0] = sev_q;
    else if (reg_addr == A_PTR) begin
      reg_rdata[PTR_VBIT]  = ptr_valid;
      reg_rdata[IDX_W-1:0] = ptr_idx;
    end else if (reg_addr == A_DET) begin
      reg_rdata[DET_FATAL] = fatal_det;
      reg_rdata[DET_NONF]  = nonfatal_det;
      reg_rdata[DET_SSE]   = sig_sys_err;
    end else begin
      for (int k = 0; k < HDR_WORDS; k++) begin
        if (reg_addr == ADDR_W'(int'(A_HDR0) + k)) reg_rdata = hdr_q[k*32 +: 32];
      end
    end
  end

  // R1: every pulse leaves its status bit set
  p_status_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse != '0) |=> ((status_q & $past(err_pulse)) == $past(err_pulse)));

  // R6: masked-only events request no message
  p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_pulse & ~mask_q) == '0) |-> (!fat_push && !nf_push));

  // R6: a request needs at least one enable
  p_enable_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fat_push || nf_push) |-> (serr_en || fatal_rep_en || nonfatal_rep_en));

  // R7: system error flag rises only with serr_en
  p_sse_serr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_sys_err) |-> $past(serr_en));

  // R8: an unmasked fatal event leaves the fatal flag set
  p_det_fatal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fat_hit |=> fatal_det);
endmodule

// File: tb/sec_uerr_reporter_tb.sv
module sec_uerr_reporter_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   err_pulse = '0;
  logic [127:0] err_hdr = '0;
  logic         serr_en = 1'b0, fatal_rep_en = 1'b0, nonfatal_rep_en = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msg_valid, msg_fatal;
  logic         msg_ready = 1'b1;
  logic         sig_sys_err, fatal_det, nonfatal_det;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_uerr_reporter u_dut (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .err_hdr(err_hdr),
    .serr_en(serr_en), .fatal_rep_en(fatal_rep_en), .nonfatal_rep_en(nonfatal_rep_en),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_fatal(msg_fatal), .msg_ready(msg_ready),
    .sig_sys_err(sig_sys_err), .fatal_det(fatal_det), .nonfatal_det(nonfatal_det)
  );

  // Behavioural reference state
  bit [2:0]   m_status, m_mask, m_sev;
  bit         m_pv;
  int         m_pi;
  bit [127:0] m_hdr;
  int         m_fq, m_nq;
  bit         m_fdet, m_ndet, m_sse;

  always @(posedge clk) begin
    bit [2:0] live, clr_s, clr_d;
    bit fatal_seen, nonf_seen, want_f, want_n, popped;
    if (!rst_n) begin
      m_status = 0; m_mask = 0; m_sev = 0; m_pv = 0; m_pi = 0; m_hdr = 0;
      m_fq = 0; m_nq = 0; m_fdet = 0; m_ndet = 0; m_sse = 0;
    end else begin
      live = err_pulse & ~m_mask;
      fatal_seen = 0; nonf_seen = 0;
      for (int i = 0; i < 3; i++) begin
        if (live[i] && m_sev[i]) fatal_seen = 1;
        if (live[i] && !m_sev[i]) nonf_seen = 1;
      end
      want_f = fatal_seen && (serr_en || fatal_rep_en);
      want_n = nonf_seen && (serr_en || nonfatal_rep_en);
      clr_s = (reg_wr && reg_addr == 4'h0) ? reg_wdata[2:0] : 3'b0;
      clr_d = (reg_wr && reg_addr == 4'h4) ? reg_wdata[2:0] : 3'b0;
      popped = msg_ready && (m_fq > 0 || m_nq > 0);
      if (popped && m_fq > 0) m_fq--; else if (popped) m_nq--;
      if (want_f) m_fq++;
      if (want_n) m_nq++;
      if (!m_pv && live != 0) begin
        m_pv = 1;
        m_hdr = err_hdr;
        for (int i = 2; i >= 0; i--) if (live[i]) m_pi = i;
      end else if (m_pv && clr_s[m_pi]) m_pv = 0;
      m_status = (m_status & ~clr_s) | err_pulse;
      if (reg_wr && reg_addr == 4'h1) m_mask = reg_wdata[2:0];
      if (reg_wr && reg_addr == 4'h2) m_sev = reg_wdata[2:0];
      m_fdet = (m_fdet & !clr_d[0]) | fatal_seen;
      m_ndet = (m_ndet & !clr_d[1]) | nonf_seen;
      m_sse  = (m_sse & !clr_d[2]) | (serr_en && (want_f || want_n));
    end
  end

  function automatic bit [31:0] model_rd(input bit [3:0] a);
    bit [31:0] r = 0;
    case (a)
      4'h0: r[2:0] = m_status;
      4'h1: r[2:0] = m_mask;
      4'h2: r[2:0] = m_sev;
      4'h3: begin r[31] = m_pv; r[1:0] = 2'(m_pi); end
      4'h4: r[2:0] = {m_sse, m_ndet, m_fdet};
      4'h8, 4'h9, 4'hA, 4'hB: r = m_hdr[(a - 4'h8) * 32 +: 32];
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input bit [3:0] a);
    case (a)
      4'h0: return "R1";
      4'h1, 4'h2: return "R10";
      4'h3: return "R4";
      4'h4: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare against the reference on every clock, away from the edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R9", "msg_valid", 32'(msg_valid), 32'(m_fq > 0 || m_nq > 0));
      check("R5", "msg_fatal", 32'(msg_fatal && msg_valid), 32'(m_fq > 0));
      check("R8", "fatal_det", 32'(fatal_det), 32'(m_fdet));
      check("R8", "nonfatal_det", 32'(nonfatal_det), 32'(m_ndet));
      check("R7", "sig_sys_err", 32'(sig_sys_err), 32'(m_sse));
      check(tag_of(reg_addr), "reg_rdata", reg_rdata, model_rd(reg_addr));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic fire(input logic [2:0] p, input logic [127:0] h);
    err_pulse = p; err_hdr = h; tick(); err_pulse = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; tick(); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #1;
    check(tag, "read", reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) tick();
    rst_n = 1'b1; cmp_on = 1; tick();
    // reset state
    rd(4'h0, 32'h0, "R1");
    rd(4'h1, 32'h0, "R10");
    rd(4'h3, 32'h0, "R2");
    rd(4'h5, 32'h0, "R10");
    check("R9", "reset msg_valid", 32'(msg_valid), 32'h0);

    // R10 readback
    wr(4'h1, 32'h2); rd(4'h1, 32'h2, "R10");
    wr(4'h2, 32'h5); rd(4'h2, 32'h5, "R10");
    wr(4'h1, 32'h0); wr(4'h2, 32'h0);

    // first error logs (R2), later one does not
    nonfatal_rep_en = 1;
    fire(3'b100, {32'hD3, 32'hC3, 32'hB3, 32'hA3});
    rd(4'h0, 32'h4, "R1");
    rd(4'h3, 32'h8000_0002, "R2");
    rd(4'h8, 32'hA3, "R2");
    rd(4'hB, 32'hD3, "R2");
    fire(3'b001, {4{32'h1111_2222}});
    rd(4'h3, 32'h8000_0002, "R2");
    rd(4'h8, 32'hA3, "R2");
    rd(4'h0, 32'h5, "R1");
    // R4: clearing another bit keeps pointer, clearing pointed bit drops it
    wr(4'h0, 32'h1); rd(4'h3, 32'h8000_0002, "R4");
    wr(4'h0, 32'h4); rd(4'h3, 32'h0000_0002, "R4");
    rd(4'h0, 32'h0, "R1");

    // R3: simultaneous, index 0 masked -> index 1 wins
    wr(4'h1, 32'h1);
    fire(3'b111, {32'h4, 32'h3, 32'h2, 32'h77});
    rd(4'h3, 32'h8000_0001, "R3");
    rd(4'h0, 32'h7, "R1");
    rd(4'h8, 32'h77, "R3");
    wr(4'h0, 32'h7);

    // R6: fully masked error sets status only
    wr(4'h1, 32'h7); wr(4'h4, 32'h7);
    fire(3'b010, {4{32'h5}});
    rd(4'h0, 32'h2, "R1");
    rd(4'h3, 32'h0000_0001, "R6");
    check("R6", "masked msg_valid", 32'(msg_valid), 32'h0);
    rd(4'h4, 32'h0, "R8");
    wr(4'h0, 32'h7);

    // R6/R8: no enables -> no message, detect still set
    wr(4'h1, 32'h0); wr(4'h2, 32'h1); nonfatal_rep_en = 0;
    fire(3'b001, {4{32'h6}});
    check("R6", "no-enable msg_valid", 32'(msg_valid), 32'h0);
    rd(4'h4, 32'h1, "R8");

    // R7: serr_en alone raises message and sys error
    serr_en = 1;
    fire(3'b010, {4{32'h8}});
    check("R6", "serr msg_valid", 32'(msg_valid), 32'h1);
    rd(4'h4, 32'h7, "R7");
    tick();
    wr(4'h4, 32'h4); rd(4'h4, 32'h3, "R7");
    serr_en = 0; fatal_rep_en = 1; nonfatal_rep_en = 1;

    // R5/R9 backlog with ready low, fatal presented first
    wr(4'h0, 32'h7); wr(4'h4, 32'h7); wr(4'h2, 32'h4);
    msg_ready = 0;
    fire(3'b001, {4{32'h9}});
    check("R9", "backlog nf valid", 32'(msg_valid), 32'h1);
    check("R5", "backlog nf kind", 32'(msg_fatal), 32'h0);
    fire(3'b100, {4{32'hA}});
    fire(3'b010, {4{32'hB}});
    check("R5", "fatal first", 32'(msg_fatal), 32'h1);
    tick();
    check("R9", "held valid", 32'(msg_valid), 32'h1);
    msg_ready = 1; tick();
    check("R5", "after fatal pop", 32'(msg_fatal), 32'h0);
    tick(); tick();
    check("R9", "drained", 32'(msg_valid), 32'h0);

    // pseudo-random phase, compared every clock
    lfsr = 16'hACE1;
    serr_en = 1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reg_addr = lfsr[3:0];
      if (n % 2 == 0) err_pulse = lfsr[6:4];
      else err_pulse = '0;
      err_hdr = {4{lfsr, ~lfsr}};
      serr_en = lfsr[7]; fatal_rep_en = lfsr[8]; nonfatal_rep_en = lfsr[9];
      reg_wr = (lfsr[11:10] == 2'b11) && (lfsr[3:0] < 4'h5);
      reg_wdata = {29'b0, lfsr[14:12]};
      tick();
    end
    err_pulse = '0; reg_wr = 0;
    repeat (6) tick();
    done = 1;
    finish_run();
  end
endmodule